// File: doc/BRIEF.md
# Iterative Bit-Sliced Block Encryption Core

This core encrypts one 128-bit block at a time using a 32-round substitution-permutation structure. The block is held as four 32-bit words. Each round mixes in a 128-bit round key with XOR. It then passes every one of the 32 bit-columns through a 4-bit substitution box. The round ends with a fixed network of rotations, shifts and XORs that spreads each bit across the words.

One round is computed per clock. The core does not hold or expand the key. Instead it puts out a key index on every busy cycle, and the surrounding logic answers in the same cycle with the matching 128-bit round key. The last round has no mixing network. In its place comes a second key XOR, which uses round key 32. A full block therefore consumes 33 round keys, from index 0 to index 32.

A block is launched by pulsing `start` with the plaintext present. Exactly 33 clocks later `done` is high for one cycle, and the ciphertext is on `cipher` during that cycle.

Top module: `sliced_cipher_core`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `key_idx` and `cipher` are all zero.
- R2: `start` sampled high while `busy` is low loads `plain` and raises `busy` on the next edge. `done` rises 33 clock edges after that loading edge, lasts exactly one cycle, and `busy` falls on the same edge.
- R3: `start` sampled while `busy` is high has no effect. Neither the result nor the completion cycle changes.
- R4: While `busy` is high, `key_idx` starts at 0 on the first busy cycle and steps up by one each cycle, ending at 32. The external `subkey` is used in the same cycle that `key_idx` requests it.
- R5: Word j of the plaintext, of every round key and of the ciphertext occupies bits [32j+31:32j]. Round-key word j is XORed into state word j.
- R6: For each bit position i, the substitution input nibble is {w3[i],w2[i],w1[i],w0[i]}, with w0 as the least significant bit. Output bit k returns to word k at position i. Round r uses box r mod 8. For inputs 0 to 15 the boxes give:
  - box 0: 3,8,15,1,10,6,5,11,14,13,4,2,7,0,9,12
  - box 1: 15,12,2,7,9,0,5,10,1,11,14,8,6,13,3,4
  - box 2: 8,6,7,9,3,12,10,15,13,1,14,4,0,11,5,2
  - box 3: 0,15,11,8,12,9,6,3,13,1,2,4,10,7,5,14
  - box 4: 1,15,8,3,12,0,11,6,2,5,4,10,9,14,7,13
  - box 5: 15,5,2,11,4,10,9,12,0,3,14,8,13,6,7,1
  - box 6: 7,2,12,5,8,4,6,11,14,9,1,15,13,3,10,0
  - box 7: 1,13,15,0,14,8,2,11,7,4,12,10,9,3,5,6
- R7: In rounds 0 to 30, the substituted words go through the following steps in order. Rotate w0 left by 13 and w2 left by 3. Set w1 ^= w0 ^ w2. Set w3 ^= w2 ^ (w0 << 3). Rotate w1 left by 1 and w3 left by 7. Set w0 ^= w1 ^ w3. Set w2 ^= w3 ^ (w1 << 7). Rotate w0 left by 5 and w2 left by 22. Shifts fill with zeros, and rotations are full 32-bit rotations.
- R8: Round 31 applies no mixing. Its substituted state is XORed with round key 32 on the following cycle.
- R9: When `done` is high, `cipher` equals the encryption of the loaded plaintext. A `start` presented during the `done` cycle is accepted, and the result on `cipher` in that cycle is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch request, sampled when idle |
| plain | input | 128 | Plaintext block |
| subkey | input | 128 | Round key answering the current `key_idx` |
| key_idx | output | 6 | Index of the round key needed this cycle |
| busy | output | 1 | Encryption in progress |
| done | output | 1 | One-cycle pulse marking a valid result |
| cipher | output | 128 | Ciphertext, valid while `done` is high |

## Verification
Two things can fall in the same cycle: a finished block is presented on `done`, and a new launch is accepted. The bench raises `start` with a fresh plaintext and key seed in the very cycle where it observes `done`. It then checks that the ciphertext seen in that cycle still matches the reference model for the earlier block, and that the second block completes correctly 33 edges later. A related case is a start request that lands mid-run. The bench pulses `start` with a different plaintext part way through a block and checks that neither the completion cycle nor the result moves.

// File: rtl/slc_pkg.sv
// Shared types and constants for the bit-sliced encryption core.
// Assumes a fixed four-word, 32-bit-per-word state.
package slc_pkg;
    localparam int WORD_W  = 32;
    localparam int NWORDS  = 4;
    localparam int BLOCK_W = WORD_W * NWORDS;
    localparam int NBOX    = 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [NWORDS-1:0] block_t;

    // Box contents packed as 16 nibbles; output for input v sits at bits [4v+3:4v].
    function automatic logic [63:0] box_row(input logic [2:0] b);
        case (b)
            3'd0:    return 64'hC90724DEB56A1F83;
            3'd1:    return 64'h43D68EB1A50972CF;
            3'd2:    return 64'h25B04E1DFAC39768;
            3'd3:    return 64'hE57A421D369C8BF0;
            3'd4:    return 64'hD7E9A4526B0C38F1;
            3'd5:    return 64'h176D8E30C9A4B25F;
            3'd6:    return 64'h0A3DF19EB6485C27;
            default: return 64'h6539AC47B28E0FD1;
        endcase
    endfunction

    function automatic logic [3:0] box_lookup(input logic [2:0] b, input logic [3:0] v);
        logic [63:0] row;
        row = box_row(b);
        return row[{v, 2'b00} +: 4];
    endfunction

    function automatic word_t rotl(input word_t x, input int n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction
endpackage

// File: rtl/slc_subst_layer.sv
// Bit-sliced substitution: every bit column of the four words forms one
// 4-bit box input (word 0 is the LSB). Purely combinational.
module slc_subst_layer
    import slc_pkg::*;
(
    input  logic [2:0] box_sel,
    input  block_t     din,
    output block_t     dout
);
    for (genvar c = 0; c < WORD_W; c++) begin : g_col
        logic [NWORDS-1:0] nib_in;
        logic [NWORDS-1:0] nib_out;
        // Gather one column, substitute, scatter back to the same column.
        always_comb begin
            for (int k = 0; k < NWORDS; k++) nib_in[k] = din[k][c];
            nib_out = box_lookup(box_sel, nib_in);
        end
        for (genvar k = 0; k < NWORDS; k++) begin : g_bit
            assign dout[k][c] = nib_out[k];
        end
    end
endmodule

// File: rtl/slc_mix_layer.sv
// Fixed linear diffusion network of rotations, zero-fill shifts and XORs.
// Purely combinational; the step order matters.
module slc_mix_layer
    import slc_pkg::*;
(
    input  block_t din,
    output block_t dout
);
    word_t a, b, c, d;

    // Apply the seven mixing steps in sequence.
    always_comb begin
        a = rotl(din[0], 13);
        c = rotl(din[2], 3);
        b = din[1] ^ a ^ c;
        d = din[3] ^ c ^ (a << 3);
        b = rotl(b, 1);
        d = rotl(d, 7);
        a = a ^ b ^ d;
        c = c ^ d ^ (b << 7);
        a = rotl(a, 5);
        c = rotl(c, 22);
        dout = {d, c, b, a};
    end
endmodule

// File: rtl/slc_round_seq.sv
// Round sequencer: accepts a launch when idle, steps the key index from 0
// to LAST (one per clock), then pulses done. Launches while busy are dropped.
module slc_round_seq #(
    parameter int LAST  = 32,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             load,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LAST);

    // Launch is honoured only when idle.
    assign load = start & ~busy;

    // Busy flag, round counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            idx  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    idx  <= '0;
                end
            end else if (idx == LAST_IDX) begin
                busy <= 1'b0;
                done <= 1'b1;
                idx  <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sliced_cipher_core.sv
// Iterative block encryption core: one round per clock. Each round XORs the
// external round key, substitutes bit-sliced, then mixes; the last round
// skips mixing and a final key XOR (key index ROUNDS) follows.
// Assumes subkey answers key_idx combinationally in the same cycle.
module sliced_cipher_core
    import slc_pkg::*;
#(
    parameter int ROUNDS = 32,
    localparam int IDX_W = $clog2(ROUNDS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [BLOCK_W-1:0] plain,
    input  logic [BLOCK_W-1:0] subkey,
    output logic [IDX_W-1:0]   key_idx,
    output logic               busy,
    output logic               done,
    output logic [BLOCK_W-1:0] cipher
);
    localparam logic [IDX_W-1:0] FINAL_IDX = IDX_W'(ROUNDS);
    localparam logic [IDX_W-1:0] PLAIN_IDX = IDX_W'(ROUNDS - 1);

    block_t state, keyed, substd, mixed, next_state;
    logic   load;

    slc_round_seq #(.LAST(ROUNDS), .IDX_W(IDX_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .busy  (busy),
        .done  (done),
        .idx   (key_idx)
    );

    // Key mixing with the round key requested this cycle.
    assign keyed = state ^ block_t'(subkey);

    slc_subst_layer u_subst (
        .box_sel (key_idx[2:0]),
        .din     (keyed),
        .dout    (substd)
    );

    slc_mix_layer u_mix (
        .din  (substd),
        .dout (mixed)
    );

    // Choose the round result: normal, last (no mixing) or final key XOR.
    always_comb begin
        if (key_idx == FINAL_IDX)      next_state = keyed;
        else if (key_idx == PLAIN_IDX) next_state = substd;
        else                           next_state = mixed;
    end

    // State register: load on launch, advance while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)    state <= '0;
        else if (load) state <= block_t'(plain);
        else if (busy) state <= next_state;
    end

    assign cipher = state;
endmodule

// File: rtl/slc_core_chk.sv
// Protocol checker for the encryption core's sequencing.
module slc_core_chk #(
    parameter int LAST  = 32,
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [IDX_W-1:0] key_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LAST);

    a_r1_idle_after_reset: assert property (@(posedge clk)
        $past(!rst_n) |-> (!busy && !done && key_idx == '0));

    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && key_idx == '0));

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && key_idx == LAST_IDX) |=> (done && !busy));

    a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && key_idx != LAST_IDX) |=> busy);

    a_r4_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && key_idx != LAST_IDX) |=> (busy && key_idx == $past(key_idx) + 1'b1));
endmodule

bind sliced_cipher_core slc_core_chk #(.LAST(ROUNDS), .IDX_W(IDX_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .key_idx (key_idx)
);

// File: tb/test_sliced_cipher_core.sv
module test_sliced_cipher_core;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] plain = '0;
    logic [127:0] subkey;
    logic [5:0]   key_idx;
    logic         busy, done;
    logic [127:0] cipher;
    logic [31:0]  kseed = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sliced_cipher_core i_sliced_cipher_core (
        .clk(clk), .rst_n(rst_n), .start(start), .plain(plain),
        .subkey(subkey), .key_idx(key_idx), .busy(busy), .done(done),
        .cipher(cipher)
    );

    function automatic logic [31:0] t_rol(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    // Round-key source; seed 0 gives all-zero keys.
    function automatic logic [127:0] key_fn(input logic [31:0] seed, input int r);
        logic [127:0] k;
        for (int j = 0; j < 4; j++) begin
            logic [31:0] w;
            w = seed ^ (32'(r) * 32'h9E3779B1) ^ (32'(j + 1) * 32'h85EBCA6B);
            w = t_rol(w, j * 5 + 1) + 32'(r);
            k[32*j +: 32] = (seed == 0) ? 32'h0 : w;
        end
        return k;
    endfunction

    always_comb subkey = key_fn(kseed, int'(key_idx));

    // Boxes written in table order: entry 0 in the top nibble.
    function automatic logic [3:0] ref_box(input int b, input int v);
        logic [63:0] t;
        case (b)
            0: t = {4'd3,4'd8,4'd15,4'd1,4'd10,4'd6,4'd5,4'd11,4'd14,4'd13,4'd4,4'd2,4'd7,4'd0,4'd9,4'd12};
            1: t = {4'd15,4'd12,4'd2,4'd7,4'd9,4'd0,4'd5,4'd10,4'd1,4'd11,4'd14,4'd8,4'd6,4'd13,4'd3,4'd4};
            2: t = {4'd8,4'd6,4'd7,4'd9,4'd3,4'd12,4'd10,4'd15,4'd13,4'd1,4'd14,4'd4,4'd0,4'd11,4'd5,4'd2};
            3: t = {4'd0,4'd15,4'd11,4'd8,4'd12,4'd9,4'd6,4'd3,4'd13,4'd1,4'd2,4'd4,4'd10,4'd7,4'd5,4'd14};
            4: t = {4'd1,4'd15,4'd8,4'd3,4'd12,4'd0,4'd11,4'd6,4'd2,4'd5,4'd4,4'd10,4'd9,4'd14,4'd7,4'd13};
            5: t = {4'd15,4'd5,4'd2,4'd11,4'd4,4'd10,4'd9,4'd12,4'd0,4'd3,4'd14,4'd8,4'd13,4'd6,4'd7,4'd1};
            6: t = {4'd7,4'd2,4'd12,4'd5,4'd8,4'd4,4'd6,4'd11,4'd14,4'd9,4'd1,4'd15,4'd13,4'd3,4'd10,4'd0};
            default: t = {4'd1,4'd13,4'd15,4'd0,4'd14,4'd8,4'd2,4'd11,4'd7,4'd4,4'd12,4'd10,4'd9,4'd3,4'd5,4'd6};
        endcase
        return t[63 - 4*v -: 4];
    endfunction

    // Behavioural reference of the whole encryption (R5..R8).
    function automatic logic [127:0] ref_enc(input logic [127:0] pt, input logic [31:0] seed);
        logic [31:0] w [4];
        logic [127:0] k;
        for (int j = 0; j < 4; j++) w[j] = pt[32*j +: 32];
        for (int r = 0; r < 32; r++) begin
            k = key_fn(seed, r);
            for (int j = 0; j < 4; j++) w[j] = w[j] ^ k[32*j +: 32];
            for (int i = 0; i < 32; i++) begin
                int v;
                logic [3:0] o;
                v = {w[3][i], w[2][i], w[1][i], w[0][i]};
                o = ref_box(r % 8, v);
                for (int j = 0; j < 4; j++) w[j][i] = o[j];
            end
            if (r < 31) begin
                w[0] = t_rol(w[0], 13);
                w[2] = t_rol(w[2], 3);
                w[1] = w[1] ^ w[0] ^ w[2];
                w[3] = w[3] ^ w[2] ^ (w[0] << 3);
                w[1] = t_rol(w[1], 1);
                w[3] = t_rol(w[3], 7);
                w[0] = w[0] ^ w[1] ^ w[3];
                w[2] = w[2] ^ w[3] ^ (w[1] << 7);
                w[0] = t_rol(w[0], 5);
                w[2] = t_rol(w[2], 22);
            end
        end
        k = key_fn(seed, 32);
        for (int j = 0; j < 4; j++) w[j] = w[j] ^ k[32*j +: 32];
        return {w[3], w[2], w[1], w[0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present a launch at a negedge; return at the negedge after it is taken.
    task automatic fire(input logic [127:0] pt, input logic [31:0] seed);
        plain = pt;
        kseed = seed;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Wait for done, tracking key indices; optionally poke start mid-run.
    task automatic await(input bit noisy, output int n, output bit idx_ok);
        n = 0;
        idx_ok = 1'b1;
        while (!done && n < 100) begin
            if (!busy || key_idx != 6'(n)) idx_ok = 1'b0;
            if (noisy && n == 10) begin start = 1'b1; plain = ~plain; end
            if (noisy && n == 11) start = 1'b0;
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_one(input logic [127:0] pt, input logic [31:0] seed, input bit noisy);
        int n;
        bit ok;
        logic [127:0] exp;
        exp = ref_enc(pt, seed);
        fire(pt, seed);
        await(noisy, n, ok);
        check(n == 33, noisy ? "R3 completion cycle" : "R2 latency", 128'(n), 128'd33);
        check(ok, "R4 key index sequence", 128'(ok), 128'd1);
        check(cipher === exp, noisy ? "R3 result unchanged" : "R9 ciphertext (R5 R6 R7 R8)", cipher, exp);
        check(!busy, "R2 busy cleared with done", 128'(busy), 128'd0);
        @(negedge clk);
        check(!done, "R2 done single cycle", 128'(done), 128'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] rs;
        logic [127:0] pt;
        int n;
        bit ok;
        logic [127:0] exp1, exp2;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy, "R1 busy", 128'(busy), 0);
        check(!done, "R1 done", 128'(done), 0);
        check(key_idx == 0, "R1 key_idx", 128'(key_idx), 0);
        check(cipher == 0, "R1 cipher", cipher, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // All-zero block and keys.
        run_one('0, 32'h0, 1'b0);

        // Column sweep: every nibble value appears in every column across v.
        for (int v = 0; v < 16; v++) begin
            pt = '0;
            for (int i = 0; i < 32; i++) begin
                logic [3:0] nb;
                nb = 4'((i + v) % 16);
                for (int j = 0; j < 4; j++) pt[32*j + i] = nb[j];
            end
            run_one(pt, (v % 2 == 0) ? 32'h0 : 32'(v * 7919 + 1), 1'b0);
        end

        // Pseudo-random blocks and keys.
        rs = 32'h1234_5678;
        for (int t = 0; t < 12; t++) begin
            for (int j = 0; j < 4; j++) begin
                rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
                pt[32*j +: 32] = rs;
            end
            run_one(pt, rs | 32'h1, 1'b0);
        end

        // R3: start pulsed mid-run with a different plaintext.
        run_one(128'hFEDC_BA98_7654_3210_0F1E_2D3C_4B5A_6978, 32'hA5A5_0001, 1'b1);
        run_one(128'h0123_4567_89AB_CDEF_0000_FFFF_AAAA_5555, 32'hC0DE_0042, 1'b1);

        // R9: new launch in the same cycle as done.
        exp1 = ref_enc(128'h1111_2222_3333_4444_5555_6666_7777_8888, 32'h0BAD_F00D);
        exp2 = ref_enc(128'h9999_AAAA_BBBB_CCCC_DDDD_EEEE_FFFF_0000, 32'h600D_CAFE);
        fire(128'h1111_2222_3333_4444_5555_6666_7777_8888, 32'h0BAD_F00D);
        await(1'b0, n, ok);
        check(done && cipher === exp1, "R9 first result in done cycle", cipher, exp1);
        fire(128'h9999_AAAA_BBBB_CCCC_DDDD_EEEE_FFFF_0000, 32'h600D_CAFE);
        check(busy && key_idx == 0, "R2 launch during done cycle", 128'(busy), 128'd1);
        await(1'b0, n, ok);
        check(n == 33, "R2 back-to-back latency", 128'(n), 128'd33);
        check(ok, "R4 back-to-back key index", 128'(ok), 128'd1);
        check(cipher === exp2, "R9 back-to-back result", cipher, exp2);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule